// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns one already-prioritised exception request into a complete handler entry in a single clock. Each request carries a vector-offset code, a fault syndrome, the faulting instruction word, the address of the next instruction and the core's current machine state word. A variant select picks between a standard core and an embedded core. The two differ in where the reset vector lands and in which save pair reset and machine check use.

When a request is taken, the block does four things. It writes a save pair with a return address and a saved state word. It drives a new state word with a write strobe. It redirects fetch to the handler vector. It may also load a syndrome register. Maskable external and timer requests are refused while interrupts are disabled, and they are remembered as pending. A machine check that arrives while machine checks are disabled raises a fatal stop. A code that does not name a known exception raises an illegal-exception error and changes nothing else.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector for each code is the code itself. The accepted codes are 0x0100, 0x0200, 0x0300, 0x0380, 0x0400, 0x0480, 0x0500, 0x0600, 0x0700, 0x0800, 0x0900, 0x0980, 0x0C00, 0x0D00, 0x0E00 and 0x0F00. On the clock edge that samples a taken request, `fetch_pc` takes the vector and `redirect` pulses high for one cycle. At most one of `redirect`, `illegal_err` and `fatal_stop` is high in any cycle.
- R2: On the standard variant (`variant_emb`=0), reset (0x0100) vectors to 0xFFF00100 when state bit 6 (vector prefix) is set, and to 0x00000100 otherwise. On the embedded variant, reset always vectors to 0x00000100.
- R3: On the embedded variant, reset and machine check (0x0200) write the secondary pair (`srr2` address, `srr3` state). Every other taken entry writes the primary pair (`srr0` address, `srr1` state), and the pair not selected is left unchanged.
- R4: Alignment (0x0600), program (0x0700) and FP-unavailable (0x0800) save `next_pc`-4 as the return address. All other taken entries save `next_pc`.
- R5: The saved state word is treated as follows:
  - Data storage (0x0300), instruction storage (0x0400), program and FP-unavailable clear bits 31:16 of the saved state.
  - Instruction storage then ORs `cause[31:16]` into those bits.
  - Program ORs `cause[31:17]` into bits 31:17 and sets bit 16.
  - Every other exception saves the state unchanged.
- R6: A taken entry pulses `state_we` and drives `state_new`. `state_new` is the current state with bit 18 (power save), bit 15 (external enable), bit 14 (problem state), bit 13 (FP available), bit 4 (data relocate) and bit 1 (recoverable) cleared, and with bit 0 (little-endian) loaded from bit 16 (interrupt little-endian). A machine check also clears bit 12 (machine-check enable).
- R7: An external (0x0500), decrementer (0x0900) or hypervisor decrementer (0x0980) request that arrives while state bit 15 is clear is not taken. An external request sets `pend_ext`, and either timer code sets `pend_tmr`. The flag clears when a request of its kind is taken.
- R8: A machine check that arrives while state bit 12 is clear pulses `fatal_stop` and performs no entry.
- R9: A request with a code outside the R1 list pulses `illegal_err` and leaves the save pairs, the syndrome and the pending flags unchanged.
- R10: Data storage loads `syndrome` with `cause`. Alignment loads `syndrome` with `insn_word[25:16]` in bits 9:0 and zero above. Other entries leave `syndrome` unchanged.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request present this cycle |
| req_code | input | 16 | Exception vector-offset code |
| variant_emb | input | 1 | 0 selects the standard core, 1 selects the embedded core |
| cause | input | 32 | Fault syndrome / subtype bits |
| insn_word | input | 32 | Faulting instruction word |
| next_pc | input | 32 | Address of the next instruction |
| cur_state | input | 32 | Current machine state word |
| redirect | output | 1 | Fetch redirect pulse |
| fetch_pc | output | 32 | Handler vector address |
| state_we | output | 1 | New state write pulse |
| state_new | output | 32 | State word loaded on entry |
| srr0 | output | 32 | Primary saved return address |
| srr1 | output | 32 | Primary saved state |
| srr2 | output | 32 | Secondary saved return address |
| srr3 | output | 32 | Secondary saved state |
| syndrome | output | 32 | Fault syndrome register |
| pend_ext | output | 1 | External request held pending |
| pend_tmr | output | 1 | Timer request held pending |
| illegal_err | output | 1 | Unknown-code error pulse |
| fatal_stop | output | 1 | Machine check while disabled |

## Verification
The embedded assertions hold on every cycle for several properties:
- the three outcome pulses never coincide;
- handler vectors stay 128-byte aligned;
- every state write has external enable and problem state cleared;
- a masked external request always leaves a pending flag and no redirect;
- an illegal code never disturbs the primary pair.

Only the directed scenarios can show the rest:
- the exact vector values, including the high reset vector;
- which pair each variant writes;
- the current-versus-next return address;
- the per-type merging of cause bits into the saved state;
- the syndrome contents;
- that a pending flag clears once interrupts are re-enabled.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 16;

  // machine state bit positions (LSB = 0)
  localparam int B_LE  = 0;
  localparam int B_RI  = 1;
  localparam int B_DR  = 4;
  localparam int B_IP  = 6;
  localparam int B_ME  = 12;
  localparam int B_FP  = 13;
  localparam int B_PR  = 14;
  localparam int B_EE  = 15;
  localparam int B_ILE = 16;
  localparam int B_POW = 18;

  typedef enum logic [1:0] {
    MRG_NONE,
    MRG_ISTOR,
    MRG_PROG
  } merge_e;

  typedef struct packed {
    logic            legal;
    logic [XLEN-1:0] vector;
    logic            save_cur;
    logic            clr_hi;
    merge_e          merge;
    logic            bank2;
    logic            ext_kind;
    logic            tmr_kind;
    logic            mchk;
    logic            dstor;
    logic            align;
  } exc_dec_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code,
  input  logic          variant_emb,
  input  logic          prefix_bit,
  output exc_dec_t      dec
);
  localparam logic [XLEN-1:0] HIGH_BASE = 32'hFFF0_0000;

  always_comb begin
    dec          = '0;
    dec.legal    = 1'b1;
    dec.vector   = XLEN'(code);
    dec.merge    = MRG_NONE;
    unique case (code)
      16'h0100: begin
        dec.bank2 = variant_emb;
        if (!variant_emb && prefix_bit) dec.vector = HIGH_BASE | XLEN'(code);
      end
      16'h0200: begin
        dec.bank2 = variant_emb;
        dec.mchk  = 1'b1;
      end
      16'h0300: begin
        dec.clr_hi = 1'b1;
        dec.dstor  = 1'b1;
      end
      16'h0400: begin
        dec.clr_hi = 1'b1;
        dec.merge  = MRG_ISTOR;
      end
      16'h0500: dec.ext_kind = 1'b1;
      16'h0600: begin
        dec.save_cur = 1'b1;
        dec.align    = 1'b1;
      end
      16'h0700: begin
        dec.save_cur = 1'b1;
        dec.clr_hi   = 1'b1;
        dec.merge    = MRG_PROG;
      end
      16'h0800: begin
        dec.save_cur = 1'b1;
        dec.clr_hi   = 1'b1;
      end
      16'h0900, 16'h0980: dec.tmr_kind = 1'b1;
      16'h0380, 16'h0480, 16'h0C00, 16'h0D00, 16'h0E00, 16'h0F00: ;
      default: begin
        dec.legal  = 1'b0;
        dec.vector = '0;
      end
    endcase
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int W = XLEN
) (
  input  exc_dec_t       dec,
  input  logic [W-1:0]   cur_state,
  input  logic [W-1:0]   cause,
  output logic [W-1:0]   saved_state,
  output logic [W-1:0]   entry_state
);
  localparam int HI = W / 2;

  always_comb begin
    saved_state = cur_state;
    if (dec.clr_hi) saved_state[W-1:HI] = '0;
    case (dec.merge)
      MRG_ISTOR: saved_state[W-1:HI] = saved_state[W-1:HI] | cause[W-1:HI];
      MRG_PROG: begin
        saved_state[W-1:HI+1] = saved_state[W-1:HI+1] | cause[W-1:HI+1];
        saved_state[HI]       = 1'b1;
      end
      default: ;
    endcase

    entry_state        = cur_state;
    entry_state[B_POW] = 1'b0;
    entry_state[B_EE]  = 1'b0;
    entry_state[B_PR]  = 1'b0;
    entry_state[B_FP]  = 1'b0;
    entry_state[B_DR]  = 1'b0;
    entry_state[B_RI]  = 1'b0;
    entry_state[B_LE]  = cur_state[B_ILE];
    if (dec.mchk) entry_state[B_ME] = 1'b0;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int W        = XLEN,
  parameter int CW       = CODE_W,
  parameter int NPAIR    = 2,
  parameter int INSN_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_code,
  input  logic          variant_emb,
  input  logic [W-1:0]  cause,
  input  logic [W-1:0]  insn_word,
  input  logic [W-1:0]  next_pc,
  input  logic [W-1:0]  cur_state,
  output logic          redirect,
  output logic [W-1:0]  fetch_pc,
  output logic          state_we,
  output logic [W-1:0]  state_new,
  output logic [W-1:0]  srr0,
  output logic [W-1:0]  srr1,
  output logic [W-1:0]  srr2,
  output logic [W-1:0]  srr3,
  output logic [W-1:0]  syndrome,
  output logic          pend_ext,
  output logic          pend_tmr,
  output logic          illegal_err,
  output logic          fatal_stop
);
  localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int RF_LO  = 16;
  localparam int RF_W   = 10;

  exc_dec_t     dec;
  logic [W-1:0] saved_state, entry_state, ret_addr;
  logic         take, masked, fatal, bad;
  logic [PAIR_W-1:0] bank;

  exc_decode #(.CW(CW)) u_dec (
    .code        (req_code),
    .variant_emb (variant_emb),
    .prefix_bit  (cur_state[B_IP]),
    .dec         (dec)
  );

  exc_state_calc #(.W(W)) u_calc (
    .dec         (dec),
    .cur_state   (cur_state),
    .cause       (cause),
    .saved_state (saved_state),
    .entry_state (entry_state)
  );

  always_comb begin
    bad      = req_valid & ~dec.legal;
    masked   = req_valid & dec.legal & (dec.ext_kind | dec.tmr_kind) & ~cur_state[B_EE];
    fatal    = req_valid & dec.legal & dec.mchk & ~cur_state[B_ME];
    take     = req_valid & dec.legal & ~masked & ~fatal;
    ret_addr = dec.save_cur ? (next_pc - W'(INSN_LEN)) : next_pc;
    bank     = PAIR_W'(dec.bank2);
  end

  // save pairs
  logic [W-1:0] pair_addr_q  [NPAIR];
  logic [W-1:0] pair_state_q [NPAIR];

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic         we;
    logic [W-1:0] addr_d, state_d;
    always_comb begin
      we      = take && (bank == PAIR_W'(g));
      addr_d  = we ? ret_addr    : pair_addr_q[g];
      state_d = we ? saved_state : pair_state_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pair_addr_q[g]  <= '0;
        pair_state_q[g] <= '0;
      end else begin
        pair_addr_q[g]  <= addr_d;
        pair_state_q[g] <= state_d;
      end
    end
  end

  assign srr0 = pair_addr_q[0];
  assign srr1 = pair_state_q[0];
  assign srr2 = pair_addr_q[NPAIR-1];
  assign srr3 = pair_state_q[NPAIR-1];

  // control and status registers
  logic         redirect_d, state_we_d, pend_ext_d, pend_tmr_d, illegal_d, fatal_d;
  logic [W-1:0] fetch_d, state_new_d, syn_d;

  always_comb begin
    redirect_d  = take;
    state_we_d  = take;
    illegal_d   = bad;
    fatal_d     = fatal;
    fetch_d     = take ? dec.vector  : fetch_pc;
    state_new_d = take ? entry_state : state_new;
    syn_d       = syndrome;
    if (take && dec.dstor) syn_d = cause;
    if (take && dec.align) syn_d = W'(insn_word[RF_LO +: RF_W]);
    pend_ext_d  = pend_ext;
    pend_tmr_d  = pend_tmr;
    if (masked && dec.ext_kind) pend_ext_d = 1'b1;
    if (take && dec.ext_kind)   pend_ext_d = 1'b0;
    if (masked && dec.tmr_kind) pend_tmr_d = 1'b1;
    if (take && dec.tmr_kind)   pend_tmr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      state_we    <= 1'b0;
      illegal_err <= 1'b0;
      fatal_stop  <= 1'b0;
      fetch_pc    <= '0;
      state_new   <= '0;
      syndrome    <= '0;
      pend_ext    <= 1'b0;
      pend_tmr    <= 1'b0;
    end else begin
      redirect    <= redirect_d;
      state_we    <= state_we_d;
      illegal_err <= illegal_d;
      fatal_stop  <= fatal_d;
      fetch_pc    <= fetch_d;
      state_new   <= state_new_d;
      syndrome    <= syn_d;
      pend_ext    <= pend_ext_d;
      pend_tmr    <= pend_tmr_d;
    end
  end

  // R1
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect, illegal_err, fatal_stop}));

  // R1
  vector_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (fetch_pc[6:0] == 7'd0));

  // R6
  entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> (!state_new[B_EE] && !state_new[B_PR]));

  // R7
  masked_ext_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_code == 16'h0500 && !cur_state[B_EE]) |=> (pend_ext && !redirect));

  // R9
  illegal_keeps_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_err |-> (srr0 == $past(srr0) && srr1 == $past(srr1)));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_code;
  logic        variant_emb;
  logic [31:0] cause, insn_word, next_pc, cur_state;
  logic        redirect, state_we, pend_ext, pend_tmr, illegal_err, fatal_stop;
  logic [31:0] fetch_pc, state_new, srr0, srr1, srr2, srr3, syndrome;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .variant_emb(variant_emb), .cause(cause), .insn_word(insn_word),
    .next_pc(next_pc), .cur_state(cur_state), .redirect(redirect),
    .fetch_pc(fetch_pc), .state_we(state_we), .state_new(state_new),
    .srr0(srr0), .srr1(srr1), .srr2(srr2), .srr3(srr3), .syndrome(syndrome),
    .pend_ext(pend_ext), .pend_tmr(pend_tmr), .illegal_err(illegal_err),
    .fatal_stop(fatal_stop)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic fire(input logic [15:0] code, input logic emb, input logic [31:0] st,
                      input logic [31:0] cs, input logic [31:0] iw, input logic [31:0] pc);
    @(negedge clk);
    req_valid = 1'b1; req_code = code; variant_emb = emb;
    cur_state = st; cause = cs; insn_word = iw; next_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R11 redirect", {31'd0, redirect}, 0);
    check("R11 fetch_pc", fetch_pc, 0);
    check("R11 srr0", srr0, 0);
    check("R11 srr3", srr3, 0);
    check("R11 syndrome", syndrome, 0);
    check("R11 flags", {27'd0, pend_ext, pend_tmr, illegal_err, fatal_stop, state_we}, 0);
  endtask

  task automatic t_syscall();
    fire(16'h0C00, 1'b0, 32'h0001_B032, 32'h0, 32'h0, 32'h0000_2000);
    check("R1 syscall redirect", {31'd0, redirect}, 1);
    check("R1 syscall vector", fetch_pc, 32'h0000_0C00);
    check("R4 syscall next addr", srr0, 32'h0000_2000);
    check("R5 syscall state kept", srr1, 32'h0001_B032);
    check("R6 syscall new state", state_new, 32'h0001_1021);
    check("R6 syscall we", {31'd0, state_we}, 1);
    @(negedge clk);
    check("R1 redirect pulse", {31'd0, redirect}, 0);
  endtask

  task automatic t_align();
    fire(16'h0600, 1'b0, 32'h0000_8000, 32'h0, 32'h7C85_302E, 32'h0000_3004);
    check("R4 align current addr", srr0, 32'h0000_3000);
    check("R10 align syndrome", syndrome, 32'h0000_0085);
    check("R6 align new state", state_new, 32'h0);
    check("R1 align vector", fetch_pc, 32'h0000_0600);
  endtask

  task automatic t_istor();
    fire(16'h0400, 1'b0, 32'hABCD_8010, 32'h4000_0000, 32'h0, 32'h0000_5000);
    check("R5 istor merge", srr1, 32'h4000_8010);
    check("R4 istor next addr", srr0, 32'h0000_5000);
    check("R6 istor new state", state_new, 32'hABC9_0001);
    check("R10 istor syndrome kept", syndrome, 32'h0000_0085);
  endtask

  task automatic t_program();
    fire(16'h0700, 1'b0, 32'h0000_4002, 32'h0002_0000, 32'h0, 32'h0000_4008);
    check("R5 program merge", srr1, 32'h0003_4002);
    check("R4 program current addr", srr0, 32'h0000_4004);
    check("R6 program new state", state_new, 32'h0);
  endtask

  task automatic t_dstor();
    fire(16'h0300, 1'b0, 32'hFFFF_0000, 32'h4200_0000, 32'h0, 32'h0000_6000);
    check("R5 dstor clear", srr1, 32'h0);
    check("R10 dstor syndrome", syndrome, 32'h4200_0000);
    check("R6 dstor new state", state_new, 32'hFFFB_0001);
  endtask

  task automatic t_reset_vec();
    fire(16'h0100, 1'b0, 32'h0000_1040, 32'h0, 32'h0, 32'h0000_7000);
    check("R2 high reset vector", fetch_pc, 32'hFFF0_0100);
    check("R3 std reset primary", srr1, 32'h0000_1040);
    fire(16'h0100, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_7100);
    check("R2 low reset vector", fetch_pc, 32'h0000_0100);
  endtask

  task automatic t_embedded();
    fire(16'h0100, 1'b1, 32'h0000_1040, 32'h0, 32'h0, 32'h0000_8000);
    check("R2 emb reset vector", fetch_pc, 32'h0000_0100);
    check("R3 emb srr2", srr2, 32'h0000_8000);
    check("R3 emb srr3", srr3, 32'h0000_1040);
    check("R3 emb primary kept", srr0, 32'h0000_7100);
    fire(16'h0200, 1'b1, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_8100);
    check("R3 emb mchk srr2", srr2, 32'h0000_8100);
    check("R3 emb mchk primary kept", srr0, 32'h0000_7100);
  endtask

  task automatic t_mchk();
    fire(16'h0200, 1'b0, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_9000);
    check("R6 mchk clears enable", state_new, 32'h0);
    check("R3 mchk std primary", srr1, 32'h0000_9000);
    fire(16'h0200, 1'b0, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_9100);
    check("R8 fatal pulse", {31'd0, fatal_stop}, 1);
    check("R8 no redirect", {31'd0, redirect}, 0);
    check("R8 pair kept", srr0, 32'h0000_9000);
  endtask

  task automatic t_masked();
    fire(16'h0500, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0000_A000);
    check("R7 ext not taken", {31'd0, redirect}, 0);
    check("R7 ext pending", {31'd0, pend_ext}, 1);
    check("R7 ext pair kept", srr0, 32'h0000_9000);
    fire(16'h0980, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0000_A100);
    check("R7 hdec pending", {31'd0, pend_tmr}, 1);
    fire(16'h0500, 1'b0, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_A200);
    check("R7 ext taken vector", fetch_pc, 32'h0000_0500);
    check("R7 ext pending cleared", {31'd0, pend_ext}, 0);
    check("R7 tmr still pending", {31'd0, pend_tmr}, 1);
    fire(16'h0900, 1'b0, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_A300);
    check("R7 dec taken clears", {31'd0, pend_tmr}, 0);
    check("R4 dec next addr", srr0, 32'h0000_A300);
  endtask

  task automatic t_illegal();
    fire(16'h1000, 1'b0, 32'h0000_8000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_B000);
    check("R9 illegal pulse", {31'd0, illegal_err}, 1);
    check("R9 no redirect", {31'd0, redirect}, 0);
    check("R9 srr0 kept", srr0, 32'h0000_A300);
    check("R9 srr2 kept", srr2, 32'h0000_8100);
    check("R9 syndrome kept", syndrome, 32'h4200_0000);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; variant_emb = 1'b0;
    cause = '0; insn_word = '0; next_pc = '0; cur_state = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_syscall();
    t_align();
    t_istor();
    t_program();
    t_dstor();
    t_reset_vec();
    t_embedded();
    t_mchk();
    t_masked();
    t_illegal();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule